// File: doc/BRIEF.md
# Branch Hazard Fetch Controller

This block steers instruction fetch around control hazards in a five-stage in-order pipeline. The five stages are fetch, decode, execute, memory and writeback, and a branch resolves in the memory stage. The decode stage reports that it holds a branch. Two cycles later, when that branch sits in the memory stage, the resolving logic supplies the outcome and the target address. The controller then tells fetch what to do next: advance sequentially, keep the current PC, or jump to the target. It also says which younger in-flight instructions must become bubbles. The pipeline makes a squashed instruction harmless by clearing its register-write and memory-enable control bits as it moves into the next stage.

There are four static handling policies, chosen per branch by a 2-bit mode input that is sampled when the branch is decoded. The first stalls fetch until the branch resolves. The second keeps fetching down the sequential path and discards that path if the branch is taken. The third always executes exactly one delay-slot instruction after the branch. The fourth also has one delay slot, but annuls it when the branch falls through.

A running count of lost issue slots lets each policy's cost be measured directly.

Top module: `bhc_fetch_ctrl`

## Requirements
- R1: Mode 2'b00 (freeze). A live branch in decode asserts `fetch_hold` and `squash_if` in its decode cycle and in the following cycle. In the resolve cycle, two cycles after decode, `squash_if` is asserted again. In that cycle a taken branch asserts `redirect`, and a not-taken branch asserts `fetch_hold`.
- R2: Mode 2'b01 (predict not taken). There is never a hold. A not-taken branch produces no output at all. A taken branch, in its resolve cycle, asserts `redirect` together with `squash_if`, `squash_id` and `squash_ex`.
- R3: Mode 2'b10 (delay slot). A taken branch, in its resolve cycle, asserts `redirect`, `squash_if` and `squash_id`, and leaves the delay-slot instruction (now in execute) alive. A not-taken branch produces no output.
- R4: Mode 2'b11 (annulling delay slot). A not-taken branch asserts only `squash_ex` in its resolve cycle, which cancels the slot instruction. A taken branch behaves as in R3.
- R5: `res_taken` and `res_target` have no effect in any cycle where no live branch occupies the memory stage.
- R6: `dec_branch` is ignored when the decode slot holds an instruction that was squashed in fetch during the previous cycle. A branch squashed in decode or execute never resolves.
- R7: `lost_slots` grows by the number of squash outputs asserted in a cycle, and the new value is visible from the next cycle on. The cost per branch (not taken / taken) is: freeze 3/3, predict-not-taken 0/3, delay slot 0/2, annulling delay slot 1/2.
- R8: During and right after reset, all steering outputs are 0 and `lost_slots` is 0.
- R9: `redirect_pc` equals `res_target` whenever `redirect` is 1, and is 0 otherwise.
- R10: The mode is captured per branch at decode. Changing `mode` while a branch is in flight does not change how that branch is handled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Policy applied to the branch now in decode |
| dec_branch | input | 1 | Decode stage holds a branch |
| res_taken | input | 1 | Outcome of the branch in the memory stage |
| res_target | input | PC_W | Target address of the branch in the memory stage |
| redirect | output | 1 | Next PC comes from `redirect_pc` |
| redirect_pc | output | PC_W | Redirect target address, 0 when no redirect |
| fetch_hold | output | 1 | Keep the PC unchanged this cycle |
| squash_if | output | 1 | Turn the instruction now in fetch into a bubble |
| squash_id | output | 1 | Turn the instruction now in decode into a bubble |
| squash_ex | output | 1 | Turn the instruction now in execute into a bubble |
| lost_slots | output | CNT_W | Running count of squashed issue slots |

## Verification
All steering outputs are combinational from the current inputs and from the branch tracker. Decode-cycle actions are therefore due in the same cycle the branch is presented, and resolution actions are due exactly two cycles later. The slot counter is due one cycle after the squash that moves it. The bench drives stimuli on the falling edge and queues the expected output vector for that same cycle; a monitor compares it a quarter period later. Counter deltas are read only after the resolve cycle's rising edge has passed.

// File: rtl/bhc_pkg.sv
package bhc_pkg;

  typedef enum logic [1:0] {
    POL_FREEZE     = 2'b00,
    POL_NOTTAKEN   = 2'b01,
    POL_SLOT       = 2'b10,
    POL_SLOT_ANNUL = 2'b11
  } bpol_e;

  typedef struct packed {
    logic redirect;
    logic hold;
    logic kill_if;
    logic kill_id;
    logic kill_ex;
  } steer_t;

  // Action taken in the cycle a branch of policy p resolves.
  function automatic steer_t resolve_action(bpol_e p, logic taken);
    steer_t a;
    a = '0;
    case (p)
      POL_FREEZE: begin
        a.kill_if  = 1'b1;
        a.redirect = taken;
        a.hold     = ~taken;
      end
      POL_NOTTAKEN: begin
        a.redirect = taken;
        a.kill_if  = taken;
        a.kill_id  = taken;
        a.kill_ex  = taken;
      end
      POL_SLOT: begin
        a.redirect = taken;
        a.kill_if  = taken;
        a.kill_id  = taken;
      end
      default: begin
        a.redirect = taken;
        a.kill_if  = taken;
        a.kill_id  = taken;
        a.kill_ex  = ~taken;
      end
    endcase
    return a;
  endfunction

  function automatic logic [1:0] kill_count(logic a, logic b, logic c);
    return {1'b0, a} + {1'b0, b} + {1'b0, c};
  endfunction

endpackage

// File: rtl/bhc_track.sv
module bhc_track
  import bhc_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  dec_branch,
  input  bpol_e pol_in,
  input  logic  kill_if,
  input  logic  kill_id,
  input  logic  kill_ex,
  output logic  id_live,
  output logic  ex_live,
  output bpol_e ex_pol,
  output logic  mem_live,
  output bpol_e mem_pol
);

  logic id_bubble_q;

  assign id_live = dec_branch & ~id_bubble_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      id_bubble_q <= 1'b0;
      ex_live     <= 1'b0;
      mem_live    <= 1'b0;
      ex_pol      <= POL_FREEZE;
      mem_pol     <= POL_FREEZE;
    end else begin
      id_bubble_q <= kill_if;
      ex_live     <= id_live & ~kill_id;
      ex_pol      <= pol_in;
      mem_live    <= ex_live & ~kill_ex;
      mem_pol     <= ex_pol;
    end
  end

  // R6: a branch squashed in execute is never seen in memory.
  assert_squashed_gone_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_live && kill_ex) |=> !mem_live);

endmodule

// File: rtl/bhc_steer.sv
module bhc_steer
  import bhc_pkg::*;
#(
  parameter int PC_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            id_live,
  input  bpol_e           pol_in,
  input  logic            ex_live,
  input  bpol_e           ex_pol,
  input  logic            mem_live,
  input  bpol_e           mem_pol,
  input  logic            res_taken,
  input  logic [PC_W-1:0] res_target,
  output steer_t          act,
  output logic [PC_W-1:0] redirect_pc
);

  logic   id_frz, ex_frz, mem_frz;
  steer_t mem_act;

  assign id_frz  = id_live  && (pol_in  == POL_FREEZE);
  assign ex_frz  = ex_live  && (ex_pol  == POL_FREEZE);
  assign mem_frz = mem_live && (mem_pol == POL_FREEZE);

  always_comb begin
    mem_act      = mem_live ? resolve_action(mem_pol, res_taken) : '0;
    act          = '0;
    act.redirect = mem_act.redirect;
    act.kill_if  = mem_act.kill_if | id_frz | ex_frz;
    act.kill_id  = mem_act.kill_id;
    act.kill_ex  = mem_act.kill_ex;
    act.hold     = (mem_act.hold | id_frz | ex_frz) & ~mem_act.redirect;
  end

  assign redirect_pc = act.redirect ? res_target : '0;

  // R1: freeze branches never overlap in the pipe.
  assert_single_freeze_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({id_frz, ex_frz, mem_frz}));

  // R5: with no live branch in memory there is no redirect and no late squash.
  assert_no_resolve_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_live |-> (!act.redirect && !act.kill_id && !act.kill_ex));

  // R9: the target is exported only during a redirect.
  assert_target_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !act.redirect |-> (redirect_pc == '0));

endmodule

// File: rtl/bhc_tally.sv
module bhc_tally
  import bhc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             kill_if,
  input  logic             kill_id,
  input  logic             kill_ex,
  output logic [CNT_W-1:0] count
);

  always_ff @(posedge clk) begin
    if (!rst_n) count <= '0;
    else        count <= count + CNT_W'(kill_count(kill_if, kill_id, kill_ex));
  end

  // R7: no squash, no change in the slot count.
  assert_idle_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!kill_if && !kill_id && !kill_ex) |=> $stable(count));

endmodule

// File: rtl/bhc_fetch_ctrl.sv
module bhc_fetch_ctrl
  import bhc_pkg::*;
#(
  parameter int PC_W  = 16,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic             dec_branch,
  input  logic             res_taken,
  input  logic [PC_W-1:0]  res_target,
  output logic             redirect,
  output logic [PC_W-1:0]  redirect_pc,
  output logic             fetch_hold,
  output logic             squash_if,
  output logic             squash_id,
  output logic             squash_ex,
  output logic [CNT_W-1:0] lost_slots
);

  bpol_e  pol_in, ex_pol, mem_pol;
  logic   id_live, ex_live, mem_live;
  steer_t act;

  assign pol_in = bpol_e'(mode);

  bhc_track u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .dec_branch(dec_branch),
    .pol_in    (pol_in),
    .kill_if   (act.kill_if),
    .kill_id   (act.kill_id),
    .kill_ex   (act.kill_ex),
    .id_live   (id_live),
    .ex_live   (ex_live),
    .ex_pol    (ex_pol),
    .mem_live  (mem_live),
    .mem_pol   (mem_pol)
  );

  bhc_steer #(.PC_W(PC_W)) u_steer (
    .clk        (clk),
    .rst_n      (rst_n),
    .id_live    (id_live),
    .pol_in     (pol_in),
    .ex_live    (ex_live),
    .ex_pol     (ex_pol),
    .mem_live   (mem_live),
    .mem_pol    (mem_pol),
    .res_taken  (res_taken),
    .res_target (res_target),
    .act        (act),
    .redirect_pc(redirect_pc)
  );

  bhc_tally #(.CNT_W(CNT_W)) u_tally (
    .clk    (clk),
    .rst_n  (rst_n),
    .kill_if(act.kill_if),
    .kill_id(act.kill_id),
    .kill_ex(act.kill_ex),
    .count  (lost_slots)
  );

  assign redirect   = act.redirect;
  assign fetch_hold = act.hold;
  assign squash_if  = act.kill_if;
  assign squash_id  = act.kill_id;
  assign squash_ex  = act.kill_ex;

  // R1: a freeze decode keeps fetch stalled in the next cycle too.
  assert_freeze_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (id_live && pol_in == POL_FREEZE) |=> (redirect || (fetch_hold && squash_if)));

  // R2: squashing decode only happens as part of a redirect.
  assert_id_squash_redirect_R2: assert property (@(posedge clk) disable iff (!rst_n)
    squash_id |-> redirect);

  // R3: every redirect discards the wrong-path fetch.
  assert_redirect_kills_fetch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> (squash_if && !fetch_hold));

  // R4: squashing execute alone happens only in the annulling mode, on fall-through.
  assert_annul_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (squash_ex && !redirect) |-> (mem_pol == POL_SLOT_ANNUL));

endmodule

// File: tb/tb_bhc_fetch_ctrl.sv
module tb_bhc_fetch_ctrl;

  localparam int PC_W  = 16;
  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [1:0]       mode;
  logic             dec_branch;
  logic             res_taken;
  logic [PC_W-1:0]  res_target;
  logic             redirect;
  logic [PC_W-1:0]  redirect_pc;
  logic             fetch_hold;
  logic             squash_if;
  logic             squash_id;
  logic             squash_ex;
  logic [CNT_W-1:0] lost_slots;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;
  bit done = 1'b0;

  typedef struct {
    logic [4:0]      v;
    logic [PC_W-1:0] pc;
    string           tag;
  } exp_t;
  exp_t sbq[$];

  always #10 clk = ~clk;

  bhc_fetch_ctrl #(.PC_W(PC_W), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .dec_branch(dec_branch),
    .res_taken(res_taken), .res_target(res_target), .redirect(redirect),
    .redirect_pc(redirect_pc), .fetch_hold(fetch_hold), .squash_if(squash_if),
    .squash_id(squash_id), .squash_ex(squash_ex), .lost_slots(lost_slots)
  );

  // Monitor: compares each queued expectation a quarter period after the drive.
  always @(negedge clk) begin
    #5;
    if (sbq.size() > 0) begin
      exp_t e;
      logic [4:0] got;
      e = sbq.pop_front();
      got = {redirect, fetch_hold, squash_if, squash_id, squash_ex};
      n_cmp++;
      if (got !== e.v || redirect_pc !== e.pc) begin
        n_bad++;
        $display("FAIL %s: got vec=%b pc=%h, expected vec=%b pc=%h",
                 e.tag, got, redirect_pc, e.v, e.pc);
      end
    end
  end

  // Vector order: {redirect, hold, squash_if, squash_id, squash_ex}.
  task automatic cyc(input logic dec, input logic [1:0] m, input logic tk,
                     input logic [PC_W-1:0] tgt, input logic [4:0] ev, input string tag);
    exp_t e;
    @(negedge clk);
    dec_branch = dec; mode = m; res_taken = tk; res_target = tgt;
    e.v = ev; e.pc = ev[4] ? tgt : '0; e.tag = tag;
    sbq.push_back(e);
  endtask

  task automatic chk_cnt(input logic [CNT_W-1:0] act, input logic [CNT_W-1:0] expv,
                         input string tag);
    n_cmp++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s: lost_slots=%0d expected %0d", tag, act, expv);
    end
  endtask

  function automatic logic [4:0] resolve_vec(input logic [1:0] m, input logic tk);
    case (m)
      2'b00:   return tk ? 5'b10100 : 5'b01100;
      2'b01:   return tk ? 5'b10111 : 5'b00000;
      2'b10:   return tk ? 5'b10110 : 5'b00000;
      default: return tk ? 5'b10110 : 5'b00001;
    endcase
  endfunction

  function automatic int cost(input logic [1:0] m, input logic tk);
    case (m)
      2'b00:   return 3;
      2'b01:   return tk ? 3 : 0;
      2'b10:   return tk ? 2 : 0;
      default: return tk ? 2 : 1;
    endcase
  endfunction

  // One isolated branch, with its expected vectors and cost (R1-R4, R7, R9).
  task automatic lone_branch(input logic [1:0] m, input logic tk, input logic [PC_W-1:0] tgt);
    logic [4:0] front;
    logic [CNT_W-1:0] base;
    string tg;
    tg = $sformatf("R1-4 mode=%0d taken=%0d", m, tk);
    front = (m == 2'b00) ? 5'b01100 : 5'b00000;
    @(negedge clk);
    base = lost_slots;
    cyc(1'b1, m, 1'b0, tgt, front, {tg, " decode"});
    cyc(1'b0, m, 1'b0, tgt, front, {tg, " execute"});
    cyc(1'b0, m, tk, tgt, resolve_vec(m, tk), {tg, " resolve R9"});
    cyc(1'b0, m, 1'b0, tgt, 5'b00000, {tg, " after"});
    chk_cnt(lost_slots, base + CNT_W'(cost(m, tk)), $sformatf("R7 cost mode=%0d taken=%0d", m, tk));
    cyc(1'b0, m, 1'b0, tgt, 5'b00000, {tg, " settle"});
  endtask

  initial begin : watchdog
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        n_bad++;
        $display("FAIL watchdog: cycles=%0d expected < 20000", cycles);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    end
  end

  initial begin : driver
    logic [CNT_W-1:0] base;
    rst_n = 1'b0; mode = 2'b00; dec_branch = 1'b0; res_taken = 1'b0; res_target = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk_cnt(lost_slots, '0, "R8 reset count");
    rst_n = 1'b1;
    cyc(1'b0, 2'b01, 1'b0, 16'h0000, 5'b00000, "R8 idle after reset");

    for (int m = 0; m < 4; m++) begin
      for (int t = 0; t < 2; t++) begin
        lone_branch(2'(m), 1'(t), 16'h1000 + 16'(m * 16 + t));
      end
    end

    // R5: resolution inputs with nothing in memory
    @(negedge clk); base = lost_slots;
    cyc(1'b0, 2'b01, 1'b1, 16'hBEEF, 5'b00000, "R5 stray taken");
    cyc(1'b0, 2'b11, 1'b0, 16'hCAFE, 5'b00000, "R5 stray not-taken annul");
    cyc(1'b0, 2'b00, 1'b1, 16'h1234, 5'b00000, "R5 stray freeze");
    chk_cnt(lost_slots, base, "R5 count unchanged");

    // R6: decode during freeze bubbles is ignored
    @(negedge clk); base = lost_slots;
    cyc(1'b1, 2'b00, 1'b0, 16'h2000, 5'b01100, "R6 freeze decode");
    cyc(1'b1, 2'b00, 1'b0, 16'h2000, 5'b01100, "R6 bubble decode 1");
    cyc(1'b1, 2'b00, 1'b1, 16'h2000, 5'b10100, "R6 bubble decode 2 resolve");
    cyc(1'b1, 2'b00, 1'b1, 16'h2004, 5'b00000, "R6 bubble decode 3");
    cyc(1'b0, 2'b00, 1'b1, 16'h2008, 5'b00000, "R6 no phantom resolve a");
    cyc(1'b0, 2'b00, 1'b1, 16'h200C, 5'b00000, "R6 no phantom resolve b");
    chk_cnt(lost_slots, base + 16'd3, "R6 R7 only one freeze charged");

    // Back-to-back predict-not-taken: first falls through, second taken
    @(negedge clk); base = lost_slots;
    cyc(1'b1, 2'b01, 1'b0, 16'h3000, 5'b00000, "R2 pair A decode");
    cyc(1'b1, 2'b01, 1'b0, 16'h3000, 5'b00000, "R2 pair B decode");
    cyc(1'b0, 2'b01, 1'b0, 16'h3000, 5'b00000, "R2 pair A not taken");
    cyc(1'b0, 2'b01, 1'b1, 16'h3040, 5'b10111, "R2 pair B taken");
    cyc(1'b0, 2'b01, 1'b0, 16'h3040, 5'b00000, "R2 pair after");
    chk_cnt(lost_slots, base + 16'd3, "R7 pair cost");

    // R6: younger branch in execute squashed by older taken branch never resolves
    @(negedge clk); base = lost_slots;
    cyc(1'b1, 2'b01, 1'b0, 16'h4000, 5'b00000, "R6 kill A decode");
    cyc(1'b1, 2'b01, 1'b0, 16'h4000, 5'b00000, "R6 kill B decode");
    cyc(1'b0, 2'b01, 1'b1, 16'h4100, 5'b10111, "R6 A taken squashes B");
    cyc(1'b0, 2'b01, 1'b1, 16'h4200, 5'b00000, "R6 B never resolves");
    chk_cnt(lost_slots, base + 16'd3, "R6 R7 kill cost");

    // R10: mode change while branch in flight
    cyc(1'b1, 2'b01, 1'b0, 16'h5000, 5'b00000, "R10 decode not-taken policy");
    cyc(1'b0, 2'b00, 1'b0, 16'h5000, 5'b00000, "R10 mode switched, no hold");
    cyc(1'b0, 2'b00, 1'b1, 16'h5500, 5'b10111, "R10 resolves with captured policy");
    cyc(1'b0, 2'b10, 1'b0, 16'h5500, 5'b00000, "R10 after");

    // R3 vs R4 on the delay-slot instruction
    cyc(1'b1, 2'b10, 1'b0, 16'h6000, 5'b00000, "R3 slot decode");
    cyc(1'b0, 2'b11, 1'b0, 16'h6000, 5'b00000, "R3 slot execute");
    cyc(1'b0, 2'b11, 1'b0, 16'h6000, 5'b00000, "R3 slot kept on fall-through");
    cyc(1'b0, 2'b10, 1'b0, 16'h6000, 5'b00000, "R3 idle");

    @(negedge clk);
    @(negedge clk);
    while (sbq.size() > 0) @(negedge clk);
    #6;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule